// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small bank of memory-mapped configuration registers. Writes to it are guarded by two independent unlock schemes. A global unlock needs two distinct 32-bit keys, written in a fixed order to a pair of kick registers. Until both have arrived, every writable register in the bank ignores the bus. One control register has a second guard: it accepts data only while a companion lock register holds a dedicated key.

A further register mixes ordinary bits with bits that can be set only once after reset. A privilege register comes out of reset with a fixed alternating pattern. Two read-only words report a live device-status input and a constant identity word whose top nibble is the silicon revision. The register contents drive output ports directly. Reads go through a registered data path.

The bus is a plain synchronous port: a byte address, a write strobe and write data on one clock edge, and read data for that address on the following cycle.

Top module: `cfg_keybank`

## Requirements
- R1: On reset the bank is locked, every once-only flag is cleared, the privilege register (byte offset 0x41C) holds 0xAAAAAAAA, the control register, lock register, reset-control register and once-write register hold zero, and the read data is zero.
- R2: Writing 0x83E70B13 to the first kick register (offset 0x38) and then 0x95A4F1E0 to the second kick register (offset 0x3C) opens the bank, and the next write to a writable register takes effect.
- R3: Writing the correct second key while the bank is locked, with no correct first key before it, leaves the bank locked.
- R4: Any value other than its own key written to either kick register locks the bank. A correct first key written while the bank is open also closes it until the second key follows.
- R5: While the bank is locked, writes to the privilege (0x41C), lock (0x40004), reset-control (0x40020) and once-write (0x4002C) registers are dropped, and their outputs and readback stay unchanged.
- R6: The control register at 0x40008 accepts a write only while the bank is open and the lock register at 0x40004 holds 0x0F0A0B00.
- R7: In the once-write register, each bit set in the mask (default 0x000000FF) can change only on the first accepted write after reset. That write sets the bit's flag even when the written value equals the stored one. Bits outside the mask follow every accepted write.
- R8: The read data in the cycle after an address is presented returns that register's value. Offset 0 returns the device-status input. Offset 8 returns the revision in bits 31:28 and the identity value in bits 27:0. The kick registers and unmapped offsets read as zero, and writes to read-only offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (20) | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| dev_status_i | input | 32 | Live device-status word, readable at offset 0 |
| cfg_ctrl_o | output | 32 | Doubly protected control register contents |
| cfg_rst_o | output | 32 | Reset-control register contents |
| cfg_wo_o | output | 32 | Once-write register contents |
| cfg_priv_o | output | 32 | Privilege register contents |

## Verification
Each write lands on the clock edge that samples it, so the register outputs and the unlock state reflect it one cycle after the stimulus. A read returns the value held before any write in that same cycle, also one cycle later. The reference model therefore forms the expected read value from its state before the operation, then applies the write. All outputs are compared one time unit after the edge. A kick write and its effect on the next register write are tested in consecutive operations, which places the unlock exactly one cycle ahead of the write it enables.

// File: rtl/cfg_keybank_pkg.sv
package cfg_keybank_pkg;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } kick_st_e;

   localparam int unsigned OFS_DEVSTAT = 32'h0000_0000;
   localparam int unsigned OFS_IDREV   = 32'h0000_0008;
   localparam int unsigned OFS_KICK_A  = 32'h0000_0038;
   localparam int unsigned OFS_KICK_B  = 32'h0000_003C;
   localparam int unsigned OFS_PRIV    = 32'h0000_041C;
   localparam int unsigned OFS_LOCK    = 32'h0004_0004;
   localparam int unsigned OFS_CTRL    = 32'h0004_0008;
   localparam int unsigned OFS_RSTCTL  = 32'h0004_0020;
   localparam int unsigned OFS_ONCE    = 32'h0004_002C;

   localparam int unsigned MAP_SPAN_BITS = 19;
   localparam int unsigned KEY_BITS      = 32;

endpackage

// File: rtl/cfg_kick_seq.sv
module cfg_kick_seq
   import cfg_keybank_pkg::*;
#(
   parameter int unsigned      DW    = 32,
   parameter logic [DW-1:0]    KEY_A = 32'h83E7_0B13,
   parameter logic [DW-1:0]    KEY_B = 32'h95A4_F1E0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_a,
   input  logic          wr_b,
   input  logic [DW-1:0] wdata,
   output logic          open_o
);

   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("cfg_kick_seq: the two kick keys must differ");
   end

   kick_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (wr_a) begin
         st_d = (wdata == KEY_A) ? KS_HALF : KS_LOCKED;
      end else if (wr_b) begin
         if (wdata != KEY_B)
            st_d = KS_LOCKED;
         else if (st_q == KS_HALF || st_q == KS_OPEN)
            st_d = KS_OPEN;
         else
            st_d = KS_LOCKED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_LOCKED;
      else        st_q <= st_d;
   end

   assign open_o = (st_q == KS_OPEN);

   assert_open_via_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != KS_OPEN) |=> (st_q != KS_OPEN) ||
         ($past(st_q) == KS_HALF && $past(wr_b) && $past(wdata) == KEY_B));

   assert_locked_needs_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == KS_LOCKED && !wr_a) |=> (st_q == KS_LOCKED));

   assert_bad_key_relocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_a && wdata != KEY_A) || (wr_b && wdata != KEY_B)) |=> !open_o);

endmodule

// File: rtl/cfg_gated_reg.sv
module cfg_gated_reg #(
   parameter int unsigned   DW      = 32,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          allow,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);

   if (DW == 0) begin : g_bad_width
      $error("cfg_gated_reg: DW must be non-zero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q <= RST_VAL;
      else if (we && allow)  q <= wdata;
   end

   assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && allow) |=> $stable(q));

endmodule

// File: rtl/cfg_once_reg.sv
module cfg_once_reg #(
   parameter int unsigned   DW        = 32,
   parameter logic [DW-1:0] RST_VAL   = '0,
   parameter logic [DW-1:0] ONCE_MASK = 32'h0000_00FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          allow,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);

   localparam int unsigned N_ONCE = $countones(ONCE_MASK);

   if (DW == 0) begin : g_bad_width
      $error("cfg_once_reg: DW must be non-zero");
   end

   logic take;
   assign take = we && allow;

   for (genvar i = 0; i < DW; i++) begin : g_bit
      if (ONCE_MASK[i]) begin : g_once
         logic done_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               done_q <= 1'b0;
               q[i]   <= RST_VAL[i];
            end else if (take && !done_q) begin
               done_q <= 1'b1;
               q[i]   <= wdata[i];
            end
         end

         assert_once_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            done_q |=> (done_q && $stable(q[i])));

         assert_once_flag_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
            take |=> done_q);
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q[i] <= RST_VAL[i];
            else if (take) q[i] <= wdata[i];
         end
      end
   end

   if (N_ONCE > DW) begin : g_bad_mask
      $error("cfg_once_reg: mask wider than register");
   end

endmodule

// File: rtl/cfg_keybank.sv
module cfg_keybank
   import cfg_keybank_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter logic [31:0] KICK_KEY_A = 32'h83E7_0B13,
   parameter logic [31:0] KICK_KEY_B = 32'h95A4_F1E0,
   parameter logic [31:0] LOCK_KEY   = 32'h0F0A_0B00,
   parameter logic [31:0] PRIV_RST   = 32'hAAAA_AAAA,
   parameter logic [31:0] CTRL_RST   = 32'h0000_0000,
   parameter logic [31:0] RSTCTL_RST = 32'h0000_0000,
   parameter logic [31:0] ONCE_RST   = 32'h0000_0000,
   parameter logic [31:0] ONCE_MASK  = 32'h0000_00FF,
   parameter logic [3:0]  SIL_REV    = 4'h2,
   parameter logic [27:0] DEV_IDENT  = 28'h012_3456
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [31:0]       dev_status_i,
   output logic [31:0]       cfg_ctrl_o,
   output logic [31:0]       cfg_rst_o,
   output logic [31:0]       cfg_wo_o,
   output logic [31:0]       cfg_priv_o
);

   localparam int unsigned DW = KEY_BITS;

   if (ADDR_W < MAP_SPAN_BITS || ADDR_W > 32) begin : g_bad_addr
      $error("cfg_keybank: ADDR_W must cover the map and fit 32 bits");
   end

   function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return 32'(a) == ofs;
   endfunction

   logic hit_stat, hit_id, hit_ka, hit_kb, hit_priv, hit_lock, hit_ctrl, hit_rst, hit_once;
   assign hit_stat = at(bus_addr, OFS_DEVSTAT);
   assign hit_id   = at(bus_addr, OFS_IDREV);
   assign hit_ka   = at(bus_addr, OFS_KICK_A);
   assign hit_kb   = at(bus_addr, OFS_KICK_B);
   assign hit_priv = at(bus_addr, OFS_PRIV);
   assign hit_lock = at(bus_addr, OFS_LOCK);
   assign hit_ctrl = at(bus_addr, OFS_CTRL);
   assign hit_rst  = at(bus_addr, OFS_RSTCTL);
   assign hit_once = at(bus_addr, OFS_ONCE);

   logic bank_open;

   cfg_kick_seq #(
      .DW    (DW),
      .KEY_A (KICK_KEY_A),
      .KEY_B (KICK_KEY_B)
   ) u_kick (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_a   (bus_we && hit_ka),
      .wr_b   (bus_we && hit_kb),
      .wdata  (bus_wdata),
      .open_o (bank_open)
   );

   logic [31:0] lock_q;

   cfg_gated_reg #(.DW(DW), .RST_VAL(PRIV_RST)) u_priv (
      .clk(clk), .rst_n(rst_n), .we(bus_we && hit_priv), .allow(bank_open),
      .wdata(bus_wdata), .q(cfg_priv_o));

   cfg_gated_reg #(.DW(DW), .RST_VAL(32'h0)) u_lock (
      .clk(clk), .rst_n(rst_n), .we(bus_we && hit_lock), .allow(bank_open),
      .wdata(bus_wdata), .q(lock_q));

   logic ctrl_allow;
   assign ctrl_allow = bank_open && (lock_q == LOCK_KEY);

   cfg_gated_reg #(.DW(DW), .RST_VAL(CTRL_RST)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(bus_we && hit_ctrl), .allow(ctrl_allow),
      .wdata(bus_wdata), .q(cfg_ctrl_o));

   assert_ctrl_needs_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q != LOCK_KEY || !bank_open) |=> $stable(cfg_ctrl_o));

   cfg_gated_reg #(.DW(DW), .RST_VAL(RSTCTL_RST)) u_rstctl (
      .clk(clk), .rst_n(rst_n), .we(bus_we && hit_rst), .allow(bank_open),
      .wdata(bus_wdata), .q(cfg_rst_o));

   cfg_once_reg #(.DW(DW), .RST_VAL(ONCE_RST), .ONCE_MASK(ONCE_MASK)) u_once (
      .clk(clk), .rst_n(rst_n), .we(bus_we && hit_once), .allow(bank_open),
      .wdata(bus_wdata), .q(cfg_wo_o));

   logic [31:0] rd_d;

   always_comb begin
      rd_d = '0;
      if (hit_stat)      rd_d = dev_status_i;
      else if (hit_id)   rd_d = {SIL_REV, DEV_IDENT};
      else if (hit_priv) rd_d = cfg_priv_o;
      else if (hit_lock) rd_d = lock_q;
      else if (hit_ctrl) rd_d = cfg_ctrl_o;
      else if (hit_rst)  rd_d = cfg_rst_o;
      else if (hit_once) rd_d = cfg_wo_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_d;
   end

   assert_kick_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ka || hit_kb) |=> (bus_rdata == '0));

   assert_status_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_stat |=> (bus_rdata == $past(dev_status_i)));

endmodule

// File: tb/cfg_keybank_tb.sv
module cfg_keybank_tb;

   localparam logic [31:0] KA   = 32'h83E7_0B13;
   localparam logic [31:0] KB   = 32'h95A4_F1E0;
   localparam logic [31:0] LKEY = 32'h0F0A_0B00;
   localparam logic [31:0] WOM  = 32'h0000_00FF;
   localparam logic [31:0] IDW  = {4'h2, 28'h012_3456};

   localparam logic [19:0] A_STAT = 20'h00000, A_ID = 20'h00008, A_KA = 20'h00038,
                           A_KB = 20'h0003C, A_PRIV = 20'h0041C, A_LOCK = 20'h40004,
                           A_CTRL = 20'h40008, A_RST = 20'h40020, A_ONCE = 20'h4002C,
                           A_NONE = 20'h00100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] dev_status_i = 32'hC0DE_0001;
   logic [31:0] cfg_ctrl_o, cfg_rst_o, cfg_wo_o, cfg_priv_o;

   always #5 clk = ~clk;

   cfg_keybank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_status_i(dev_status_i),
      .cfg_ctrl_o(cfg_ctrl_o), .cfg_rst_o(cfg_rst_o), .cfg_wo_o(cfg_wo_o),
      .cfg_priv_o(cfg_priv_o));

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int          m_ks;
   logic [31:0] m_priv, m_lock, m_ctrl, m_rst, m_once, m_flag, m_rd;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic m_reset();
      m_ks = 0; m_priv = 32'hAAAA_AAAA; m_lock = 0; m_ctrl = 0;
      m_rst = 0; m_once = 0; m_flag = 0; m_rd = 0;
   endtask

   function automatic logic [31:0] m_read(input logic [19:0] a);
      case (a)
         A_STAT: return dev_status_i;
         A_ID:   return IDW;
         A_PRIV: return m_priv;
         A_LOCK: return m_lock;
         A_CTRL: return m_ctrl;
         A_RST:  return m_rst;
         A_ONCE: return m_once;
         default: return 32'h0;
      endcase
   endfunction

   task automatic m_write(input logic [19:0] a, input logic [31:0] d);
      bit open;
      open = (m_ks == 2);
      case (a)
         A_KA: m_ks = (d == KA) ? 1 : 0;
         A_KB: m_ks = (d != KB) ? 0 : ((m_ks == 0) ? 0 : 2);
         A_PRIV: if (open) m_priv = d;
         A_LOCK: if (open) m_lock = d;
         A_CTRL: if (open && m_lock == LKEY) m_ctrl = d;
         A_RST:  if (open) m_rst = d;
         A_ONCE: if (open) begin
            for (int i = 0; i < 32; i++) begin
               if (WOM[i]) begin
                  if (!m_flag[i]) begin m_once[i] = d[i]; m_flag[i] = 1'b1; end
               end else m_once[i] = d[i];
            end
         end
         default: ;
      endcase
   endtask

   task automatic cmp_all(input string tag);
      chk(tag, "rdata", bus_rdata, m_rd);
      chk(tag, "ctrl",  cfg_ctrl_o, m_ctrl);
      chk(tag, "rst",   cfg_rst_o,  m_rst);
      chk(tag, "once",  cfg_wo_o,   m_once);
      chk(tag, "priv",  cfg_priv_o, m_priv);
   endtask

   task automatic op(input string tag, input logic [19:0] a, input logic we,
                     input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_wdata = d;
      m_rd = m_read(a);
      if (we) m_write(a, d);
      @(posedge clk);
      #1;
      cmp_all(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = A_NONE;
      m_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      cmp_all("R1");
   endtask

   initial begin
      m_reset();
      do_reset();
      // R1: reset values through readback
      op("R1", A_PRIV, 0, 0);
      op("R1", A_CTRL, 0, 0);
      op("R1", A_ONCE, 0, 0);
      // R8: read-only and unmapped words
      op("R8", A_STAT, 0, 0);
      op("R8", A_ID, 0, 0);
      op("R8", A_KA, 0, 0);
      op("R8", A_NONE, 0, 0);
      op("R8", A_ID, 1, 32'hFFFF_FFFF);
      op("R8", A_ID, 0, 0);
      dev_status_i = 32'h1357_9BDF;
      op("R8", A_STAT, 0, 0);
      // R5: locked writes dropped
      op("R5", A_PRIV, 1, 32'h1234_5678);
      op("R5", A_RST, 1, 32'h0000_00F0);
      op("R5", A_PRIV, 0, 0);
      // R3: second key alone
      op("R3", A_KB, 1, KB);
      op("R3", A_PRIV, 1, 32'h1111_1111);
      op("R3", A_PRIV, 0, 0);
      // R4: first key then wrong second
      op("R4", A_KA, 1, KA);
      op("R4", A_KB, 1, 32'hDEAD_BEEF);
      op("R4", A_RST, 1, 32'h0000_0055);
      // R2: proper sequence
      op("R2", A_KA, 1, KA);
      op("R2", A_KB, 1, KB);
      op("R2", A_PRIV, 1, 32'h5555_0000);
      op("R2", A_RST, 1, 32'h0004_0000);
      op("R2", A_KA, 0, 0);
      op("R2", A_RST, 0, 0);
      // R6: control needs lock key
      op("R6", A_CTRL, 1, 32'h0000_0003);
      op("R6", A_LOCK, 1, LKEY);
      op("R6", A_LOCK, 0, 0);
      op("R6", A_CTRL, 1, 32'h4000_000C);
      op("R6", A_LOCK, 1, LKEY ^ 32'h1);
      op("R6", A_CTRL, 1, 32'h0000_0000);
      op("R6", A_CTRL, 0, 0);
      // R7: once bits; first write equals reset value
      op("R7", A_ONCE, 1, 32'h0000_0000);
      op("R7", A_ONCE, 1, 32'hFFFF_FFFF);
      op("R7", A_ONCE, 1, 32'h1200_00A5);
      op("R7", A_ONCE, 0, 0);
      // R4: wrong first key relocks, correct first key while open closes
      op("R4", A_KA, 1, 32'h0000_0000);
      op("R4", A_PRIV, 1, 32'h7777_7777);
      op("R4", A_KA, 1, KA);
      op("R4", A_KB, 1, KB);
      op("R4", A_KA, 1, KA);
      op("R4", A_RST, 1, 32'h0000_0001);
      op("R4", A_KB, 1, KB);
      op("R4", A_RST, 1, 32'h0000_0002);
      // R1/R7: reset clears once flags
      do_reset();
      op("R1", A_KA, 1, KA);
      op("R1", A_KB, 1, KB);
      op("R7", A_ONCE, 1, 32'h0000_005A);
      op("R7", A_ONCE, 1, 32'h0000_00A5);
      op("R7", A_ONCE, 0, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule